// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This unit forms an effective address from up to three parts: a signed constant displacement, a base register value and an index register value. The index is multiplied by a power of two chosen by a 2-bit scale code. Each part comes with its own present flag. A part that is flagged absent takes its neutral value: zero for the displacement, the base and the index, and a factor of one for the scale. This lets one datapath serve every operand form, from a bare displacement to the full base, index and scale form.

The result is a 64-bit address held in a register. It appears one clock after the unit accepts an input. The unit makes no memory access, so it serves both memory operands and the load-effective-address operation. The register-file reads that supply base and index happen upstream. Instruction decoding and fault checks on the address happen elsewhere. A valid/ready handshake sits on both sides, and the unit holds its result until the consumer takes it.

Top module: `agu_scaled`

## Requirements
- R1: With all parts present, `ea_addr` equals displacement plus base plus (index shifted left by the scale code).
- R2: Scale code values 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8 respectively.
- R3: When `disp_present` is 0, the displacement contributes 0, whatever value is on `disp_val`.
- R4: When `base_present` is 0, the base contributes 0, whatever value is on `base_val`.
- R5: When `index_present` is 0, the index term is 0, whatever the index value and the scale code.
- R6: When `scale_present` is 0, the index is multiplied by 1, whatever the scale code.
- R7: The 32-bit displacement is sign-extended to 64 bits (bit 31 copied upward) before it is added.
- R8: The sum wraps modulo 2^64 and no overflow indication exists.
- R9: An input accepted on a rising edge (`in_valid` and `in_ready` both high) gives `out_valid` high with its address after that edge. `out_valid` falls after an edge where the output is taken and no new input is accepted.
- R10: `in_ready` is low exactly while `out_valid` is high and `out_ready` is low. During that time `ea_addr` and `out_valid` stay unchanged, and an offered input is ignored.
- R11: A synchronous active-high `rst` clears `out_valid` on the next rising edge and drives `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operand parts are offered |
| in_ready | output | 1 | Unit can take an input this cycle |
| disp_present | input | 1 | Displacement is part of the operand |
| disp_val | input | 32 | Signed displacement constant |
| base_present | input | 1 | Base register is part of the operand |
| base_val | input | 64 | Base register value |
| index_present | input | 1 | Index register is part of the operand |
| index_val | input | 64 | Index register value |
| scale_present | input | 1 | Scale code is given |
| scale_code | input | 2 | Left shift applied to the index (0..3) |
| out_valid | output | 1 | `ea_addr` holds a result |
| out_ready | input | 1 | Consumer takes the result |
| ea_addr | output | 64 | Effective address |

## Verification
The address is tried with full operands at each of the four scale codes, so that a wrong shift amount shows up as a distinct value. Each absent-part case puts a large nonzero value on the ignored field, so a leaked term changes the result. Negative displacements, including the most negative one, separate sign extension from zero extension. Sums that pass 2^64 on the base path and on the shifted-index path confirm the wraparound. A stalled consumer with a competing input on offer shows whether the held result is overwritten, and a reset while a result is pending shows that the result is dropped.

// File: rtl/agu_scaled.sv
module agu_scaled #(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               disp_present,
  input  logic [DISP_W-1:0]  disp_val,
  input  logic               base_present,
  input  logic [ADDR_W-1:0]  base_val,
  input  logic               index_present,
  input  logic [ADDR_W-1:0]  index_val,
  input  logic               scale_present,
  input  logic [SCALE_W-1:0] scale_code,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [ADDR_W-1:0]  ea_addr
);

  localparam int EXT_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0]  disp_term;
  logic [ADDR_W-1:0]  base_term;
  logic [ADDR_W-1:0]  index_term;
  logic [SCALE_W-1:0] shift_amt;
  logic [ADDR_W-1:0]  sum_next;
  logic               take_in;

  assign disp_term  = disp_present ? {{EXT_W{disp_val[DISP_W-1]}}, disp_val} : '0;
  assign base_term  = base_present ? base_val : '0;
  assign shift_amt  = scale_present ? scale_code : '0;
  assign index_term = index_present ? (index_val << shift_amt) : '0;
  assign sum_next   = disp_term + base_term + index_term;

  assign in_ready = !out_valid || out_ready;
  assign take_in  = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      ea_addr   <= '0;
    end else if (take_in) begin
      out_valid <= 1'b1;
      ea_addr   <= sum_next;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/agu_scaled_chk.sv
module agu_scaled_chk #(
  parameter int ADDR_W  = 64,
  parameter int DISP_W  = 32,
  parameter int SCALE_W = 2
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic               in_ready,
  input logic               disp_present,
  input logic [DISP_W-1:0]  disp_val,
  input logic               base_present,
  input logic [ADDR_W-1:0]  base_val,
  input logic               index_present,
  input logic [ADDR_W-1:0]  index_val,
  input logic               scale_present,
  input logic [SCALE_W-1:0] scale_code,
  input logic               out_valid,
  input logic               out_ready,
  input logic [ADDR_W-1:0]  ea_addr
);

  logic [ADDR_W-1:0] model;
  logic              fire;

  always_comb begin
    model = '0;
    if (disp_present)
      model = ADDR_W'(signed'(disp_val));
    if (base_present)
      model = model + base_val;
    if (index_present)
      model = model + index_val * (ADDR_W'(1) << (scale_present ? scale_code : '0));
  end

  assign fire = in_valid && in_ready;

  p_reset_clear_r11: assert property (@(posedge clk) rst |=> !out_valid);

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    fire |=> out_valid);

  p_result_r1: assert property (@(posedge clk) disable iff (rst)
    fire |=> ea_addr == $past(model));

  p_drain_r9: assert property (@(posedge clk) disable iff (rst)
    (!fire && out_ready) |=> !out_valid);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(ea_addr)));

  p_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

endmodule

bind agu_scaled agu_scaled_chk #(
  .ADDR_W(ADDR_W), .DISP_W(DISP_W), .SCALE_W(SCALE_W)
) u_chk (.*);

// File: tb/agu_scaled_tb.sv
module agu_scaled_tb;

  typedef struct packed {
    logic        dp;
    logic [31:0] disp;
    logic        bp;
    logic [63:0] base;
    logic        ip;
    logic [63:0] idx;
    logic        sp;
    logic [1:0]  sc;
    logic [63:0] exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 32'h10,       1'b1, 64'h1000,             1'b1, 64'h3,                 1'b1, 2'd2, 64'h101C},
    '{1'b1, 32'h0,        1'b1, 64'h2000,             1'b1, 64'h5,                 1'b1, 2'd3, 64'h2028},
    '{1'b1, 32'h1,        1'b1, 64'h0,                1'b1, 64'h7,                 1'b1, 2'd0, 64'h8},
    '{1'b0, 32'hFFFF,     1'b1, 64'h100,              1'b1, 64'h10,                1'b1, 2'd1, 64'h120},
    '{1'b1, 32'hFFFFFFF0, 1'b1, 64'h1000,             1'b0, 64'h55,                1'b1, 2'd3, 64'hFF0},
    '{1'b1, 32'h40,       1'b0, 64'hDEAD,             1'b1, 64'h2,                 1'b1, 2'd2, 64'h48},
    '{1'b0, 32'h0,        1'b1, 64'h1000,             1'b1, 64'h10,                1'b0, 2'd3, 64'h1010},
    '{1'b1, 32'h1,        1'b1, 64'hFFFFFFFFFFFFFFFF, 1'b0, 64'h0,                 1'b0, 2'd0, 64'h0},
    '{1'b0, 32'h0,        1'b1, 64'h5,                1'b1, 64'h8000000000000000,  1'b1, 2'd1, 64'h5},
    '{1'b1, 32'h80000000, 1'b0, 64'h0,                1'b0, 64'h0,                 1'b0, 2'd0, 64'hFFFFFFFF80000000},
    '{1'b0, 32'h1234,     1'b0, 64'h77,               1'b0, 64'h99,                1'b0, 2'd3, 64'h0}
  };
  localparam string VTAG [NV] = '{"R1 R2", "R2", "R2", "R3", "R5 R7",
                                  "R4", "R6", "R8", "R8", "R7", "R3 R4 R5 R6"};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        disp_present = 1'b0;
  logic [31:0] disp_val = '0;
  logic        base_present = 1'b0;
  logic [63:0] base_val = '0;
  logic        index_present = 1'b0;
  logic [63:0] index_val = '0;
  logic        scale_present = 1'b0;
  logic [1:0]  scale_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] ea_addr;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  agu_scaled u_dut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    disp_present = v.dp;  disp_val = v.disp;
    base_present = v.bp;  base_val = v.base;
    index_present = v.ip; index_val = v.idx;
    scale_present = v.sp; scale_code = v.sc;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 out_valid in reset", 64'(out_valid), 64'd0);
    chk("R11 in_ready in reset", 64'(in_ready), 64'd1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      chk({VTAG[i], " R9 out_valid"}, 64'(out_valid), 64'd1);
      chk({VTAG[i], " address"}, ea_addr, VECS[i].exp);
    end

    @(negedge clk);
    chk("R9 out_valid falls when drained", 64'(out_valid), 64'd0);

    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    drive(VECS[1]);
    chk("R10 in_ready low while stalled", 64'(in_ready), 64'd0);
    repeat (2) @(negedge clk);
    chk("R10 held out_valid", 64'(out_valid), 64'd1);
    chk("R10 held address ignores offered input", ea_addr, VECS[0].exp);
    out_ready = 1'b1;
    #1;
    chk("R10 in_ready returns with out_ready", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 back-to-back accept", ea_addr, VECS[1].exp);
    chk("R9 out_valid stays up on refill", 64'(out_valid), 64'd1);

    out_ready = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset drops pending result", 64'(out_valid), 64'd0);
    chk("R11 in_ready after reset", 64'(in_ready), 64'd1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule